// File: doc/BRIEF.md
# Signed Decimal Result Display Formatter

This block turns a 5-bit arithmetic result and its three status flags into drive patterns for four active-low seven-segment digits and one overflow lamp. Two digits carry the decimal magnitude of the result, from 00 to 30, tens on the left. A third digit shows a '1' when a carry was produced. A fourth digit shows a minus dash when the result is negative. Values that cannot be shown are blanked.

When a subtraction has gone negative, the arithmetic unit delivers the result in two's-complement form. When both the negative and the overflow flags are present, the formatter negates the value again before decimal decoding, so the digits show the magnitude. The two magnitude digits follow the result combinationally. The carry digit, the sign digit and the overflow lamp come from flag registers. These registers load only while the output-capture enable is high and hold their value while it is low.

Every digit bus uses bit 6 for segment a, down to bit 0 for segment g. A 0 lights a segment.

Top module: `disp_fmt_top`

## Requirements
- R1: For a displayed value v in 0..30, segDigits[13:7] shows the tens digit of v and segDigits[6:0] shows the ones digit. Each digit bus is active-low, with bit 6 = a down to bit 0 = g. Lit patterns (abcdefg) are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R2: When the displayed value is 31, both magnitude digits are all ones (7'h7F, blank).
- R3: When negFlag and ovfFlag are both 1, the displayed value is the 5-bit two's complement of result. For example, 11011 shows 05 and 00001 gives 31, which is blank.
- R4: When only one of negFlag or ovfFlag is 1, or neither is, the displayed value is result unchanged.
- R5: After a rising clock edge with captureEn=1, segCarry is 7'h4F (a lit '1') if carryFlag was 1 at that edge, and 7'h7F otherwise.
- R6: After a rising clock edge with captureEn=1, segSign is 7'h7E (only segment g lit) if negFlag was 1 at that edge, and 7'h7F otherwise.
- R7: After a rising clock edge with captureEn=1, ovfLamp equals the ovfFlag sampled at that edge.
- R8: While captureEn=0, segCarry, segSign and ovfLamp keep their values across clock edges, whatever the flag inputs do.
- R9: While rstN=0, segCarry and segSign are 7'h7F and ovfLamp is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rstN | input | 1 | Asynchronous active-low reset |
| result | input | 5 | Result value from the arithmetic unit |
| carryFlag | input | 1 | Carry produced by addition or doubling |
| negFlag | input | 1 | Result of a subtraction is negative |
| ovfFlag | input | 1 | Subtraction overflow (result is in two's-complement form) |
| captureEn | input | 1 | Output-capture enable; flag registers load while high |
| segDigits | output | 14 | Tens digit in [13:7], ones digit in [6:0], active-low |
| segCarry | output | 7 | Carry digit, active-low |
| segSign | output | 7 | Sign digit, active-low |
| ovfLamp | output | 1 | Overflow indicator, active-high |

## Verification
The magnitude path is tried with these plain values:
- 0, 7, 10, 19 and 30 test each digit pattern and the tens/ones split, including the upper edge of the range.
- 31 tests blanking.

Results with both negative and overflow set tell re-negation apart from pass-through:
- 11011 must show 05.
- 10001 must show 15.
- 00000 must stay 00.
- 00001 must become blank.

Two further patterns show that one flag alone does not trigger the correction: negative without overflow, and overflow without negative.

The flag digits and the lamp are checked in two conditions:
- Flags are toggled while the enable is low; nothing may change.
- Flags are captured with the enable high; the outputs must follow.

This separates a correct hold from registers that load every cycle.

// File: rtl/disp_fmt_pkg.sv
package disp_fmt_pkg;

  localparam int SegW = 7;

  localparam logic [SegW-1:0] SEG_BLANK = 7'h7F;
  localparam logic [SegW-1:0] SEG_DASH  = 7'h7E;
  localparam logic [SegW-1:0] SEG_ONE   = 7'h4F;

  typedef struct packed {
    logic showCarry;
    logic showMinus;
    logic lampOn;
  } flag_strobe_t;

  // Active-low pattern for one decimal digit, bit 6 = a .. bit 0 = g
  function automatic logic [SegW-1:0] digitToSeg(input logic [3:0] d);
    logic [SegW-1:0] lit;
    case (d)
      4'd0:    lit = 7'b1111110;
      4'd1:    lit = 7'b0110000;
      4'd2:    lit = 7'b1101101;
      4'd3:    lit = 7'b1111001;
      4'd4:    lit = 7'b0110011;
      4'd5:    lit = 7'b1011011;
      4'd6:    lit = 7'b1011111;
      4'd7:    lit = 7'b1110000;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1111011;
      default: lit = 7'b0000000;
    endcase
    return ~lit;
  endfunction

endpackage

// File: rtl/disp_fmt_ctrl.sv
module disp_fmt_ctrl
  import disp_fmt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         captureEn,
  input  logic         carryIn,
  input  logic         negIn,
  input  logic         ovfIn,
  output flag_strobe_t strobe
);

  flag_strobe_t flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (captureEn) begin
      flagQ.showCarry <= carryIn;
      flagQ.showMinus <= negIn;
      flagQ.lampOn    <= ovfIn;
    end
  end

  assign strobe = flagQ;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !captureEn |=> $stable(strobe)); // R8

  AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> strobe.showCarry == $past(carryIn)); // R5

endmodule

// File: rtl/disp_fmt_dp.sv
module disp_fmt_dp
  import disp_fmt_pkg::*;
#(
  parameter int ResultWidth = 5,
  parameter int MaxShow     = 30
) (
  input  logic [ResultWidth-1:0] resultIn,
  input  logic                   negIn,
  input  logic                   ovfIn,
  input  flag_strobe_t           strobe,
  output logic [2*SegW-1:0]      segDigits,
  output logic [SegW-1:0]        segCarry,
  output logic [SegW-1:0]        segSign,
  output logic                   ovfLamp
);

  localparam int NumDigits = 2;

  logic [ResultWidth-1:0] magnitude;
  logic                   inRange;

  // Re-negate a negative subtraction result for display only
  always_comb begin
    if (negIn && ovfIn) magnitude = ResultWidth'(~resultIn + 1'b1);
    else                magnitude = resultIn;
    inRange = (int'(magnitude) <= MaxShow);
  end

  for (genvar i = 0; i < NumDigits; i++) begin : g_digit
    localparam int PlaceVal = 10 ** i;
    logic [3:0] digitVal;
    always_comb begin
      digitVal = 4'((int'(magnitude) / PlaceVal) % 10);
      segDigits[i*SegW +: SegW] = inRange ? digitToSeg(digitVal) : SEG_BLANK;
    end
  end

  assign segCarry = strobe.showCarry ? SEG_ONE  : SEG_BLANK;
  assign segSign  = strobe.showMinus ? SEG_DASH : SEG_BLANK;
  assign ovfLamp  = strobe.lampOn;

endmodule

// File: rtl/disp_fmt_top.sv
module disp_fmt_top
  import disp_fmt_pkg::*;
#(
  parameter int ResultWidth = 5,
  parameter int MaxShow     = 30
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ResultWidth-1:0] result,
  input  logic                   carryFlag,
  input  logic                   negFlag,
  input  logic                   ovfFlag,
  input  logic                   captureEn,
  output logic [2*SegW-1:0]      segDigits,
  output logic [SegW-1:0]        segCarry,
  output logic [SegW-1:0]        segSign,
  output logic                   ovfLamp
);

  flag_strobe_t strobe;

  disp_fmt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .captureEn (captureEn),
    .carryIn   (carryFlag),
    .negIn     (negFlag),
    .ovfIn     (ovfFlag),
    .strobe    (strobe)
  );

  disp_fmt_dp #(
    .ResultWidth (ResultWidth),
    .MaxShow     (MaxShow)
  ) u_dp (
    .resultIn  (result),
    .negIn     (negFlag),
    .ovfIn     (ovfFlag),
    .strobe    (strobe),
    .segDigits (segDigits),
    .segCarry  (segCarry),
    .segSign   (segSign),
    .ovfLamp   (ovfLamp)
  );

  AST_LAMP_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> ovfLamp == $past(ovfFlag)); // R7

  AST_SIGN_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    segSign == SEG_DASH || segSign == SEG_BLANK); // R6

  AST_CARRY_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    segCarry == SEG_ONE || segCarry == SEG_BLANK); // R5

  AST_BLANK_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (segDigits[13:7] == SEG_BLANK) == (segDigits[6:0] == SEG_BLANK)); // R2

endmodule

// File: tb/sim_disp_fmt_top.sv
module sim_disp_fmt_top;

  localparam int ClkPeriod = 10;
  localparam logic [3:0] BLK = 4'd15;

  typedef struct packed {
    logic [4:0] res;
    logic       neg;
    logic       ovf;
    logic [3:0] expTens;
    logic [3:0] expOnes;
  } vec_t;

  localparam int NumVec = 12;
  localparam vec_t VECS [NumVec] = '{
    '{5'd0,  1'b0, 1'b0, 4'd0, 4'd0},   // R1 zero
    '{5'd7,  1'b0, 1'b0, 4'd0, 4'd7},   // R1
    '{5'd10, 1'b0, 1'b0, 4'd1, 4'd0},   // R1
    '{5'd19, 1'b0, 1'b0, 4'd1, 4'd9},   // R1
    '{5'd30, 1'b0, 1'b0, 4'd3, 4'd0},   // R1 upper edge
    '{5'd31, 1'b0, 1'b0, BLK,  BLK },   // R2
    '{5'd27, 1'b1, 1'b1, 4'd0, 4'd5},   // R3 -5
    '{5'd17, 1'b1, 1'b1, 4'd1, 4'd5},   // R3 -15
    '{5'd1,  1'b1, 1'b1, BLK,  BLK },   // R3 corrected to 31
    '{5'd0,  1'b1, 1'b1, 4'd0, 4'd0},   // R3 zero stays zero
    '{5'd9,  1'b1, 1'b0, 4'd0, 4'd9},   // R4 neg only
    '{5'd25, 1'b0, 1'b1, 4'd2, 4'd5}    // R4 ovf only
  };

  logic clk = 1'b0;
  logic rstN;
  logic [4:0] result;
  logic carryFlag, negFlag, ovfFlag, captureEn;
  logic [13:0] segDigits;
  logic [6:0] segCarry, segSign;
  logic ovfLamp;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  disp_fmt_top u0 (
    .clk(clk), .rstN(rstN), .result(result), .carryFlag(carryFlag),
    .negFlag(negFlag), .ovfFlag(ovfFlag), .captureEn(captureEn),
    .segDigits(segDigits), .segCarry(segCarry), .segSign(segSign),
    .ovfLamp(ovfLamp)
  );

  // Expected active-low pattern from the R1 table; 15 means blank
  function automatic logic [6:0] expSeg(input logic [3:0] d);
    logic [6:0] lit;
    case (d)
      4'd0: lit = 7'b1111110;  4'd1: lit = 7'b0110000;
      4'd2: lit = 7'b1101101;  4'd3: lit = 7'b1111001;
      4'd4: lit = 7'b0110011;  4'd5: lit = 7'b1011011;
      4'd6: lit = 7'b1011111;  4'd7: lit = 7'b1110000;
      4'd8: lit = 7'b1111111;  4'd9: lit = 7'b1111011;
      default: lit = 7'b0000000;
    endcase
    return ~lit;
  endfunction

  task automatic chk(input string tag, input logic [13:0] got, input logic [13:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic stepClk();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(ClkPeriod * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    result = '0;
    carryFlag = 1'b1;
    negFlag = 1'b1;
    ovfFlag = 1'b1;
    captureEn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 carry digit in reset", 14'(segCarry), 14'h7F);
    chk("R9 sign digit in reset", 14'(segSign), 14'h7F);
    chk("R9 lamp in reset", 14'(ovfLamp), 14'd0);
    @(negedge clk);
    captureEn = 1'b0;
    rstN = 1'b1;

    // Table walk of the magnitude path (flags held, captureEn low)
    for (int i = 0; i < NumVec; i++) begin
      @(negedge clk);
      result  = VECS[i].res;
      negFlag = VECS[i].neg;
      ovfFlag = VECS[i].ovf;
      #1;
      chk($sformatf("R1-R4 vector %0d digits", i), segDigits,
          {expSeg(VECS[i].expTens), expSeg(VECS[i].expOnes)});
    end

    // R8: flags toggled while capture is off must not reach the outputs
    @(negedge clk);
    carryFlag = 1'b1; negFlag = 1'b1; ovfFlag = 1'b1; captureEn = 1'b0;
    stepClk();
    chk("R8 carry held while disabled", 14'(segCarry), 14'h7F);
    chk("R8 sign held while disabled", 14'(segSign), 14'h7F);
    chk("R8 lamp held while disabled", 14'(ovfLamp), 14'd0);

    // R5 R6 R7: capture all flags set
    @(negedge clk);
    captureEn = 1'b1;
    stepClk();
    chk("R5 carry digit shows one", 14'(segCarry), 14'h4F);
    chk("R6 sign digit shows dash", 14'(segSign), 14'h7E);
    chk("R7 lamp lit", 14'(ovfLamp), 14'd1);

    // R8: clear the inputs with capture off, outputs keep the lit state
    @(negedge clk);
    captureEn = 1'b0; carryFlag = 1'b0; negFlag = 1'b0; ovfFlag = 1'b0;
    stepClk();
    stepClk();
    chk("R8 carry kept", 14'(segCarry), 14'h4F);
    chk("R8 sign kept", 14'(segSign), 14'h7E);
    chk("R8 lamp kept", 14'(ovfLamp), 14'd1);

    // R5 R6 R7: capture a mixed pattern (carry only)
    @(negedge clk);
    captureEn = 1'b1; carryFlag = 1'b1;
    stepClk();
    chk("R5 carry only captured", 14'(segCarry), 14'h4F);
    chk("R6 sign blank when not negative", 14'(segSign), 14'h7F);
    chk("R7 lamp off when no overflow", 14'(ovfLamp), 14'd0);

    // R6 R7 without carry
    @(negedge clk);
    carryFlag = 1'b0; negFlag = 1'b1; ovfFlag = 1'b1;
    stepClk();
    chk("R5 carry blank when clear", 14'(segCarry), 14'h7F);
    chk("R6 dash again", 14'(segSign), 14'h7E);
    chk("R7 lamp lit again", 14'(ovfLamp), 14'd1);

    // R9: reset mid-run clears the flag indicators
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R9 carry after reset", 14'(segCarry), 14'h7F);
    chk("R9 sign after reset", 14'(segSign), 14'h7F);
    chk("R9 lamp after reset", 14'(ovfLamp), 14'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule